// File: doc/BRIEF.md
# Crossbar Column Crosspoint Arbiter

This block serves one memory-module column of a processor-to-memory crossbar. Each of `N_PORTS` processors presents a request line, a read/write flag, an address and write data. When several processors want the same module together, the column picks one of them and closes that single crosspoint. It then passes the chosen processor's access to the one memory port and holds the connection until the memory reports completion.

When the access finishes, the column returns a one-cycle acknowledge to the processor it served and to no other. For a read, that processor receives the memory's data in the same cycle as the acknowledge. Arbitration is round-robin. The priority pointer moves to the processor after the one just chosen, so a waiting requester is never starved. A requester keeps its request and its signals steady until it sees its acknowledge, and then drops the request.

Top module: `xbar_col_arbiter`

## Requirements
- R1: At most one bit of `grant_o` (the closed crosspoint) is set in any cycle.
- R2: A crosspoint closes only for a processor whose `req_i` bit was high on the clock edge that made the choice. While the column is idle, a pending request is granted on that edge, so `grant_o` shows it in the next cycle.
- R3: Round-robin choice: the column grants the first requesting index at or after the priority pointer, counting upward with wrap-around. The pointer resets to 0 and moves to (granted index + 1) mod `N_PORTS` at each grant. With all ports requesting continuously, each port is served within one round of the others.
- R4: While a crosspoint is closed, `mem_req_o` is 1 and `mem_we_o`, `mem_addr_o` and `mem_wdata_o` carry the granted processor's inputs. The inputs of ports without a grant have no effect on the memory port. When no crosspoint is closed, `mem_req_o` is 0.
- R5: The grant does not change from the cycle it appears until the cycle in which `mem_done_i` is seen. It is released (all zero) in the following cycle.
- R6: In the cycle after `mem_done_i` is seen, `ack_o` pulses for exactly one cycle on the bit of the granted processor. Every other processor sees `ack_o` low throughout.
- R7: For a read (`we`=0), `rdata_o` holds the value `mem_rdata_i` had in the `mem_done_i` cycle, and it is valid in the acknowledge cycle.
- R8: No grant is present in the acknowledge cycle. Arbitration resumes on the edge that ends the cycle after the acknowledge.
- R9: After reset, `grant_o`, `ack_o` and `mem_req_o` are all zero.
- R10: Requests that are not granted stay pending and are each served exactly once later. No request is lost or served twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_PORTS | One request line per processor |
| we_i | input | N_PORTS | Per-processor write flag (1 = write, 0 = read) |
| addr_i | input | N_PORTS*ADDR_W | Packed addresses, port p at bits [p*ADDR_W +: ADDR_W] |
| wdata_i | input | N_PORTS*DATA_W | Packed write data, port p at bits [p*DATA_W +: DATA_W] |
| grant_o | output | N_PORTS | One-hot closed crosspoint, zero when open |
| ack_o | output | N_PORTS | One-cycle completion pulse to the served processor |
| rdata_o | output | DATA_W | Read data, valid with the acknowledge |
| mem_req_o | output | 1 | Access active on the memory port |
| mem_we_o | output | 1 | Write flag towards memory |
| mem_addr_o | output | ADDR_W | Address towards memory |
| mem_wdata_o | output | DATA_W | Write data towards memory |
| mem_done_i | input | 1 | One-cycle completion pulse from memory |
| mem_rdata_i | input | DATA_W | Read data from memory, valid with the done pulse |

## Verification
The bench sweeps every non-empty request pattern of a four-port column, both from an idle column and while the priority pointer sits at each possible position. A fixed-priority arbiter, or one whose pointer does not move past the winner, would pick the wrong port in many of these patterns. Requests that arrive while another access is in flight test the hold rule: a column that re-arbitrated mid-access would swap the memory address and write data under the memory's feet. The acknowledge cycle is timed against a fixed-latency memory, so an acknowledge sent early, on the done cycle rather than after it, or to a port that merely waits, shows up as a timing or routing mismatch. A long run with all ports contending checks that service counts stay within one of each other, which a starving arbiter would break.

// File: rtl/xbar_col_pkg.sv
package xbar_col_pkg;

   typedef enum logic [1:0] {
      COL_IDLE = 2'd0,
      COL_BUSY = 2'd1,
      COL_ACK  = 2'd2
   } col_state_t;

   // width of an index into n items, at least one bit
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/xcol_rr_pick.sv
module xcol_rr_pick #(
   parameter int N_PORTS = 4,
   localparam int PW = xbar_col_pkg::idx_width(N_PORTS)
) (
   input  logic [N_PORTS-1:0] req_i,
   input  logic [PW-1:0]      ptr_i,
   output logic               any_o,
   output logic [N_PORTS-1:0] pick_oh_o,
   output logic [PW-1:0]      pick_idx_o
);

   // scan from the pointer upward, wrapping, first requester wins
   always_comb begin
      int j;
      j          = 0;
      any_o      = 1'b0;
      pick_oh_o  = '0;
      pick_idx_o = '0;
      for (int k = 0; k < N_PORTS; k++) begin
         j = (int'(ptr_i) + k) % N_PORTS;
         if (!any_o && req_i[j]) begin
            any_o        = 1'b1;
            pick_oh_o[j] = 1'b1;
            pick_idx_o   = PW'(j);
         end
      end
   end

endmodule

// File: rtl/xcol_path_mux.sv
module xcol_path_mux #(
   parameter int N_PORTS = 4,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32
) (
   input  logic [N_PORTS-1:0]        sel_oh_i,
   input  logic [N_PORTS-1:0]        we_i,
   input  logic [N_PORTS*ADDR_W-1:0] addr_i,
   input  logic [N_PORTS*DATA_W-1:0] wdata_i,
   output logic                      we_o,
   output logic [ADDR_W-1:0]         addr_o,
   output logic [DATA_W-1:0]         wdata_o
);

   logic [N_PORTS-1:0]  we_m;
   logic [ADDR_W-1:0]   addr_m  [N_PORTS];
   logic [DATA_W-1:0]   wdata_m [N_PORTS];

   // one crosspoint per port: gate its lines with its select
   for (genvar p = 0; p < N_PORTS; p++) begin : g_xpt
      assign we_m[p]    = we_i[p] & sel_oh_i[p];
      assign addr_m[p]  = addr_i[p*ADDR_W +: ADDR_W] & {ADDR_W{sel_oh_i[p]}};
      assign wdata_m[p] = wdata_i[p*DATA_W +: DATA_W] & {DATA_W{sel_oh_i[p]}};
   end

   always_comb begin
      addr_o  = '0;
      wdata_o = '0;
      for (int p = 0; p < N_PORTS; p++) begin
         addr_o  = addr_o  | addr_m[p];
         wdata_o = wdata_o | wdata_m[p];
      end
   end

   assign we_o = |we_m;

endmodule

// File: rtl/xcol_ack_route.sv
module xcol_ack_route #(
   parameter int N_PORTS = 4,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done_i,
   input  logic [N_PORTS-1:0] grant_i,
   input  logic [DATA_W-1:0]  mem_rdata_i,
   output logic [N_PORTS-1:0] ack_o,
   output logic [DATA_W-1:0]  rdata_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_o   <= '0;
         rdata_o <= '0;
      end else begin
         ack_o <= done_i ? grant_i : '0;
         if (done_i) begin
            rdata_o <= mem_rdata_i;
         end
      end
   end

endmodule

// File: rtl/xbar_col_arbiter.sv
module xbar_col_arbiter #(
   parameter int N_PORTS = 4,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_PORTS-1:0]        req_i,
   input  logic [N_PORTS-1:0]        we_i,
   input  logic [N_PORTS*ADDR_W-1:0] addr_i,
   input  logic [N_PORTS*DATA_W-1:0] wdata_i,
   output logic [N_PORTS-1:0]        grant_o,
   output logic [N_PORTS-1:0]        ack_o,
   output logic [DATA_W-1:0]         rdata_o,
   output logic                      mem_req_o,
   output logic                      mem_we_o,
   output logic [ADDR_W-1:0]         mem_addr_o,
   output logic [DATA_W-1:0]         mem_wdata_o,
   input  logic                      mem_done_i,
   input  logic [DATA_W-1:0]         mem_rdata_i
);
   import xbar_col_pkg::*;

   localparam int PW = idx_width(N_PORTS);
   localparam logic [PW-1:0] LAST_IDX = PW'(N_PORTS - 1);

   if (N_PORTS < 2) begin : g_chk_ports
      $error("xbar_col_arbiter: N_PORTS must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_chk_widths
      $error("xbar_col_arbiter: ADDR_W and DATA_W must be positive");
   end

   col_state_t          state_q;
   logic [N_PORTS-1:0]  grant_q;
   logic [PW-1:0]       ptr_q;
   logic                pick_any;
   logic [N_PORTS-1:0]  pick_oh;
   logic [PW-1:0]       pick_idx;
   logic [PW-1:0]       ptr_nx;
   logic                done_seen;

   xcol_rr_pick #(.N_PORTS(N_PORTS)) u_pick (
      .req_i      (req_i),
      .ptr_i      (ptr_q),
      .any_o      (pick_any),
      .pick_oh_o  (pick_oh),
      .pick_idx_o (pick_idx)
   );

   assign ptr_nx    = (pick_idx == LAST_IDX) ? '0 : pick_idx + PW'(1);
   assign done_seen = (state_q == COL_BUSY) && mem_done_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= COL_IDLE;
         grant_q <= '0;
         ptr_q   <= '0;
      end else begin
         unique case (state_q)
            COL_IDLE: begin
               if (pick_any) begin
                  grant_q <= pick_oh;
                  ptr_q   <= ptr_nx;
                  state_q <= COL_BUSY;
               end
            end
            COL_BUSY: begin
               if (mem_done_i) begin
                  grant_q <= '0;
                  state_q <= COL_ACK;
               end
            end
            default: begin
               state_q <= COL_IDLE;
            end
         endcase
      end
   end

   xcol_path_mux #(
      .N_PORTS (N_PORTS),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_path (
      .sel_oh_i (grant_q),
      .we_i     (we_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .we_o     (mem_we_o),
      .addr_o   (mem_addr_o),
      .wdata_o  (mem_wdata_o)
   );

   xcol_ack_route #(
      .N_PORTS (N_PORTS),
      .DATA_W  (DATA_W)
   ) u_ack (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (done_seen),
      .grant_i     (grant_q),
      .mem_rdata_i (mem_rdata_i),
      .ack_o       (ack_o),
      .rdata_o     (rdata_o)
   );

   assign grant_o   = grant_q;
   assign mem_req_o = (state_q == COL_BUSY);

endmodule

// File: rtl/xcol_sva.sv
module xcol_sva #(
   parameter int N_PORTS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_PORTS-1:0] req_i,
   input logic [N_PORTS-1:0] grant_o,
   input logic [N_PORTS-1:0] ack_o,
   input logic               mem_req_o,
   input logic               mem_done_i
);

   // R1
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R2
   grant_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o != '0 && $past(grant_o) == '0) |-> ((grant_o & $past(req_i)) == grant_o));

   // R4
   path_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (grant_o != '0));

   // R5
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o != '0 && !mem_done_i) |=> (grant_o == $past(grant_o)));

   // R6
   ack_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o != '0 && mem_done_i) |=> (ack_o == $past(grant_o) && grant_o == '0));

   // R6
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o != '0) |=> (ack_o == '0));

   // R8
   no_grant_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o != '0) |-> (grant_o == '0));

endmodule

bind xbar_col_arbiter xcol_sva #(.N_PORTS(N_PORTS)) u_xcol_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .grant_o    (grant_o),
   .ack_o      (ack_o),
   .mem_req_o  (mem_req_o),
   .mem_done_i (mem_done_i)
);

// File: tb/xbar_col_arbiter_bench.sv
`timescale 1ns/1ps
module xbar_col_arbiter_bench;
   localparam int N   = 4;
   localparam int AW  = 4;
   localparam int DW  = 8;
   localparam int LAT = 3;
   localparam int MD  = 1 << AW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;
   logic rst_n;

   logic [N-1:0]    req_r, we_r;
   logic [AW-1:0]   addr_r [N];
   logic [DW-1:0]   wd_r   [N];
   logic [N*AW-1:0] addr_f;
   logic [N*DW-1:0] wd_f;
   for (genvar p = 0; p < N; p++) begin : g_flat
      assign addr_f[p*AW +: AW] = addr_r[p];
      assign wd_f[p*DW +: DW]   = wd_r[p];
   end

   logic [N-1:0]  grant_o, ack_o;
   logic [DW-1:0] rdata_o;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mdone;
   logic [DW-1:0] mrdata;

   xbar_col_arbiter #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) u_xbar_col_arbiter (
      .clk(clk), .rst_n(rst_n), .req_i(req_r), .we_i(we_r), .addr_i(addr_f), .wdata_i(wd_f),
      .grant_o(grant_o), .ack_o(ack_o), .rdata_o(rdata_o),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .mem_done_i(mdone), .mem_rdata_i(mrdata));

   // fixed-latency memory model
   logic [DW-1:0] mem [MD];
   int mcnt;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcnt  <= 0;
         mdone <= 1'b0;
      end else begin
         mdone <= 1'b0;
         if (mem_req && !mdone) begin
            if (mcnt == LAT - 1) begin
               mdone  <= 1'b1;
               mcnt   <= 0;
               mrdata <= mem[mem_addr];
               if (mem_we) mem[mem_addr] <= mem_wdata;
            end else begin
               mcnt <= mcnt + 1;
            end
         end
      end
   end

   int total = 0, bad = 0;
   int ptr_m = 0, held = -1, lat = 0;
   logic [DW-1:0] shadow [MD];
   int served [N];
   logic [N-1:0] just_acked;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int rr_pick(input logic [N-1:0] r, input int p);
      for (int k = 0; k < N; k++) begin
         if (r[(p + k) % N]) return (p + k) % N;
      end
      return -1;
   endfunction

   task automatic set_req(input int p, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_r[p]  = 1'b1;
      we_r[p]   = w;
      addr_r[p] = a;
      wd_r[p]   = d;
   endtask

   task automatic check_path(input int p);
      chk(mem_req == 1'b1, "R4 mem_req", 32'(mem_req), 1);
      chk(mem_addr == addr_r[p] && mem_we == we_r[p], "R4 addr/we", 32'({mem_we, mem_addr}), 32'({we_r[p], addr_r[p]}));
      chk(mem_wdata == wd_r[p], "R4 wdata", 32'(mem_wdata), 32'(wd_r[p]));
   endtask

   task automatic step();
      int e;
      @(negedge clk);
      just_acked = '0;
      if ($countones(grant_o) > 1) chk(0, "R1 onehot", 32'(grant_o), 0);
      if (held < 0) begin
         if (ack_o != '0) chk(0, "R6 stray ack", 32'(ack_o), 0);
         if (grant_o != '0) begin
            e = rr_pick(req_r, ptr_m);
            chk((grant_o & req_r) == grant_o, "R2 grant to requester", 32'(grant_o), 32'(req_r));
            chk(e >= 0 && grant_o == N'(1 << e), "R3 rr choice", 32'(grant_o), 32'(1 << e));
            held  = e;
            lat   = 0;
            ptr_m = (e + 1) % N;
            check_path(held);
         end else if (mem_req) begin
            chk(0, "R4 mem_req without grant", 1, 0);
         end
      end else begin
         lat++;
         if (lat < LAT + 1) begin
            chk(grant_o == N'(1 << held), "R5 grant held", 32'(grant_o), 32'(1 << held));
            chk(ack_o == '0, "R6 early ack", 32'(ack_o), 0);
            check_path(held);
         end else begin
            chk(ack_o == N'(1 << held), "R6 ack routing", 32'(ack_o), 32'(1 << held));
            chk(grant_o == '0, "R8 grant in ack cycle", 32'(grant_o), 0);
            chk(mem_req == 1'b0, "R5 released", 32'(mem_req), 0);
            if (we_r[held]) shadow[addr_r[held]] = wd_r[held];
            else chk(rdata_o == shadow[addr_r[held]], "R7 read data", 32'(rdata_o), 32'(shadow[addr_r[held]]));
            served[held]++;
            req_r[held]      = 1'b0;
            just_acked[held] = 1'b1;
            held = -1;
         end
      end
   endtask

   task automatic drain(input string tag);
      int w;
      w = 0;
      while (req_r != '0 && w < 400) begin
         step();
         w++;
      end
      chk(req_r == '0, tag, 32'(req_r), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      chk(0, "watchdog", 0, 1);
      if (!finished) begin
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      req_r = '0;
      we_r  = '0;
      for (int p = 0; p < N; p++) begin
         addr_r[p] = '0;
         wd_r[p]   = '0;
         served[p] = 0;
      end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(grant_o == '0, "R9 grant", 32'(grant_o), 0);
      chk(ack_o == '0, "R9 ack", 32'(ack_o), 0);
      chk(mem_req == 1'b0, "R9 mem_req", 32'(mem_req), 0);
      rst_n = 1'b1;
      step();

      // preload every address, one port at a time
      for (int a = 0; a < MD; a++) begin
         set_req(a % N, 1'b1, AW'(a), DW'(a * 7 + 3));
         drain("R10 preload");
      end

      // every non-empty request pattern, mixed reads and writes, twice for pointer spread
      for (int rnd = 0; rnd < 2; rnd++) begin
         for (int pat = 1; pat < (1 << N); pat++) begin
            int cnt0 [N];
            int pop;
            pop = 0;
            for (int p = 0; p < N; p++) begin
               cnt0[p] = served[p];
               if (pat[p]) begin
                  set_req(p, ((pat + p + rnd) % 2) == 1, AW'((pat * 3 + p * 5) % MD),
                          DW'(pat * 11 + p * 29 + rnd));
                  pop++;
               end
            end
            drain("R10 pattern drained");
            for (int p = 0; p < N; p++) begin
               chk(served[p] - cnt0[p] == (pat[p] ? 1 : 0), "R10 served once",
                   32'(served[p] - cnt0[p]), 32'(pat[p]));
            end
         end
      end

      // late arrivals while an access is in flight
      set_req(2, 1'b0, 4'd5, 8'h00);
      step();
      step();
      set_req(0, 1'b1, 4'd9, 8'hA5);
      set_req(3, 1'b0, 4'd9, 8'h00);
      drain("R10 late arrivals");

      // all ports contending for a long run: fairness
      begin
         int base [N];
         int mx, mn;
         for (int p = 0; p < N; p++) base[p] = served[p];
         for (int c = 0; c < 300; c++) begin
            for (int p = 0; p < N; p++) begin
               if (!req_r[p] && !just_acked[p])
                  set_req(p, (c % 3) == 0, AW'((c + p * 4) % MD), DW'(c + p));
            end
            step();
         end
         drain("R10 contention drained");
         mx = 0;
         mn = 1 << 30;
         for (int p = 0; p < N; p++) begin
            if (served[p] - base[p] > mx) mx = served[p] - base[p];
            if (served[p] - base[p] < mn) mn = served[p] - base[p];
         end
         chk(mx - mn <= 1 && mn > 0, "R3 fairness spread", 32'(mx - mn), 1);
      end

      repeat (4) step();
      chk(grant_o == '0 && mem_req == 1'b0, "R5 idle after drain", 32'(grant_o), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule